// File: doc/BRIEF.md
# Boot Strap Capture and External Request Front End

This block sits between three multi-purpose input pins and the rest of the chip. While reset is held, it reads a clock-enable strap pin on every clock edge. It also tracks the three pins as boot-mode straps. When reset is released, the value seen at the last reset edge becomes the boot mode, and the strap enable is frozen.

After a fixed guard window of four clock edges, the same three active-low pins act as external interrupt requests. Index 0 and index 1 are maskable requests. Each of them can be set to level or falling-edge detection. Index 2 is a non-maskable request that detects falling edges only. Every pin goes through a two-flop synchroniser before any decision is made. Edge-detected requests are held as pending until acknowledged. While the chip is in its stop state, a falling edge on request 0 produces a one-cycle wake pulse. Software can replace the boot mode through a write port once reset is over.

Top module: `xirq_strap_ctrl`

## Requirements
- R1: `clk_en` takes the value of `clken_strap` at each clock edge while `rst_n` is low. After reset is released it holds that value whatever `clken_strap` does.
- R2: During reset, `boot_mode` takes `req_pins_n` on each clock edge. Bit i of `boot_mode` comes from pin i. After release it keeps the value from the last reset edge until a mode write occurs.
- R3: When `mode_wr_en` is high at a clock edge after reset, `boot_mode` shows `mode_wr_data` from that edge on.
- R4: `irq_live` is low during reset and for the first three edges after release. It rises at the fourth edge after release and stays high. While `irq_live` is low, `irq_pend` is all zero.
- R5: Each pin passes through two synchronising flops. A level-configured request that goes low shows on `irq_pend` after the second clock edge.
- R6: Request i (0 or 1) is in level mode when `trig_edge[i]` is 0. In level mode its pending bit is high exactly while its synchronised pin is low and `irq_mask[i]` is 0. `irq_ack[i]` has no effect in this mode.
- R7: Request i is in edge mode when `trig_edge[i]` is 1; index 2 is always in edge mode. In edge mode, a high-to-low change of the synchronised pin sets a pending flag at the third edge after the pin falls. The flag stays set when the pin returns high. It clears at the next edge on which `irq_ack[i]` is 1.
- R8: If a new falling edge and an acknowledge arrive at the same clock edge, the pending flag is set.
- R9: `irq_mask[i]` = 1 hides pending request i (0 or 1) on `irq_pend`. A falling edge captured while masked still appears once the mask is cleared.
- R10: Request 2 cannot be masked and never behaves as a level request. After it is acknowledged, holding its pin low does not make it pending again.
- R11: `wake` is a one-cycle pulse at the third edge after pin 0 falls. It fires only if `stop_state` is high on the edge where the fall is detected and `irq_live` is high, regardless of mask and trigger settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_pins_n | input | 3 | Boot-mode straps in reset, active-low requests afterwards (2 = non-maskable) |
| clken_strap | input | 1 | Clock-enable strap pin sampled in reset |
| trig_edge | input | 2 | Per maskable request: 1 = falling edge, 0 = level |
| irq_mask | input | 2 | Per maskable request: 1 = masked |
| irq_ack | input | 3 | Per request acknowledge, clears edge pending flags |
| mode_wr_en | input | 1 | Boot-mode overwrite strobe |
| mode_wr_data | input | 3 | New boot-mode value |
| stop_state | input | 1 | High while the chip is stopped |
| boot_mode | output | 3 | Latched or written operating mode |
| clk_en | output | 1 | Latched clock-enable strap |
| irq_live | output | 1 | High once the pins act as requests |
| irq_pend | output | 3 | Pending requests after masking |
| wake | output | 1 | One-cycle wake pulse from request 0 in stop state |

## Verification
The bench targets the reset-release boundary. A strap pin moved right after release must not leak into `boot_mode` or `clk_en`. A design that samples one edge late would show the new values. Pins held low as straps must not raise a pending request when the guard window closes. A design that detects edges during the guard window would do exactly that. The bench measures synchroniser depth by cycle count, since one flop too few shows the request an edge early. It also drives the corners where an acknowledge coincides with a new fall, or where the non-maskable pin stays low after acknowledge. There, a wrong design would either drop the request or repeat it.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int unsigned NREQ   = 3;
    localparam int unsigned NMASK  = 2;
    localparam int unsigned NMI_IX = 2;
    localparam int unsigned GUARD  = 4;

    typedef struct packed {
        logic prev;
        logic hit;
    } chan_st_t;

    typedef struct packed {
        logic wake;
    } top_st_t;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int unsigned W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.s1 = RST_VAL;
            st_d.s2 = RST_VAL;
        end else begin
            st_d.s1 = din;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/xirq_strap.sv
module xirq_strap #(
    parameter int unsigned MODE_W = 3,
    parameter int unsigned DELAY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              clken_pin,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode,
    output logic              clken,
    output logic              live
);
    localparam int unsigned CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DELAY);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              clken;
        logic [CNT_W-1:0]  cnt;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.mode  = mode_pins;
            st_d.clken = clken_pin;
            st_d.cnt   = '0;
        end else begin
            if (st_q.cnt != CNT_END) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (wr_en) begin
                st_d.mode = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode  = st_q.mode;
    assign clken = st_q.clken;
    assign live  = (st_q.cnt == CNT_END);
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
    import xirq_pkg::*;
#(
    parameter bit EDGE_ONLY = 1'b0,
    parameter bit MASKABLE  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic req_n,
    input  logic edge_mode,
    input  logic mask,
    input  logic ack,
    output logic pend,
    output logic fall
);
    chan_st_t st_d, st_q;
    logic use_edge;
    logic hide;

    assign use_edge = EDGE_ONLY ? 1'b1 : edge_mode;
    assign hide     = MASKABLE  ? mask : 1'b0;
    assign fall     = st_q.prev & ~req_n;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_n;
        if (!rst_n) begin
            st_d.prev = 1'b1;
            st_d.hit  = 1'b0;
        end else if (!use_edge) begin
            st_d.hit = 1'b0;
        end else if (live && fall) begin
            st_d.hit = 1'b1;
        end else if (ack) begin
            st_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend = use_edge ? (st_q.hit & ~hide)
                           : (live & ~req_n & ~hide);
endmodule

// File: rtl/xirq_strap_ctrl.sv
module xirq_strap_ctrl
    import xirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req_pins_n,
    input  logic             clken_strap,
    input  logic [NMASK-1:0] trig_edge,
    input  logic [NMASK-1:0] irq_mask,
    input  logic [NREQ-1:0]  irq_ack,
    input  logic             mode_wr_en,
    input  logic [NREQ-1:0]  mode_wr_data,
    input  logic             stop_state,
    output logic [NREQ-1:0]  boot_mode,
    output logic             clk_en,
    output logic             irq_live,
    output logic [NREQ-1:0]  irq_pend,
    output logic             wake
);
    logic [NREQ-1:0] req_sync;
    logic [NREQ-1:0] fall;
    top_st_t st_d, st_q;

    xirq_sync #(.W(NREQ), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_pins_n),
        .dout (req_sync)
    );

    xirq_strap #(.MODE_W(NREQ), .DELAY(GUARD)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_pins(req_pins_n),
        .clken_pin(clken_strap),
        .wr_en    (mode_wr_en),
        .wr_data  (mode_wr_data),
        .mode     (boot_mode),
        .clken    (clk_en),
        .live     (irq_live)
    );

    for (genvar gi = 0; gi < NMASK; gi++) begin : g_mchan
        xirq_chan #(.EDGE_ONLY(1'b0), .MASKABLE(1'b1)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (irq_live),
            .req_n    (req_sync[gi]),
            .edge_mode(trig_edge[gi]),
            .mask     (irq_mask[gi]),
            .ack      (irq_ack[gi]),
            .pend     (irq_pend[gi]),
            .fall     (fall[gi])
        );
    end

    xirq_chan #(.EDGE_ONLY(1'b1), .MASKABLE(1'b0)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (irq_live),
        .req_n    (req_sync[NMI_IX]),
        .edge_mode(1'b1),
        .mask     (1'b0),
        .ack      (irq_ack[NMI_IX]),
        .pend     (irq_pend[NMI_IX]),
        .fall     (fall[NMI_IX])
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = rst_n & stop_state & irq_live & fall[0];
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wake = st_q.wake;
endmodule

// File: rtl/xirq_strap_ctrl_chk.sv
module xirq_strap_ctrl_chk
    import xirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NREQ-1:0]  irq_ack,
    input logic             mode_wr_en,
    input logic [NREQ-1:0]  mode_wr_data,
    input logic             stop_state,
    input logic [NREQ-1:0]  boot_mode,
    input logic             clk_en,
    input logic             irq_live,
    input logic [NREQ-1:0]  irq_pend,
    input logic             wake
);
    p_clken_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(clk_en));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_wr_en)) |-> $stable(boot_mode));

    p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_wr_en)) |-> (boot_mode == $past(mode_wr_data)));

    p_quiet_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_live |-> (irq_pend == '0));

    p_live_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_live |=> irq_live);

    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[NMI_IX] && !irq_ack[NMI_IX]) |=> irq_pend[NMI_IX]);

    p_wake_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(stop_state));

    p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
endmodule

bind xirq_strap_ctrl xirq_strap_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_ack     (irq_ack),
    .mode_wr_en  (mode_wr_en),
    .mode_wr_data(mode_wr_data),
    .stop_state  (stop_state),
    .boot_mode   (boot_mode),
    .clk_en      (clk_en),
    .irq_live    (irq_live),
    .irq_pend    (irq_pend),
    .wake        (wake)
);

// File: tb/xirq_strap_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_strap_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req_pins_n;
    logic       clken_strap;
    logic [1:0] trig_edge;
    logic [1:0] irq_mask;
    logic [2:0] irq_ack;
    logic       mode_wr_en;
    logic [2:0] mode_wr_data;
    logic       stop_state;
    logic [2:0] boot_mode;
    logic       clk_en;
    logic       irq_live;
    logic [2:0] irq_pend;
    logic       wake;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    xirq_strap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_pins_n(req_pins_n), .clken_strap(clken_strap),
        .trig_edge(trig_edge), .irq_mask(irq_mask), .irq_ack(irq_ack),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .stop_state(stop_state),
        .boot_mode(boot_mode), .clk_en(clk_en), .irq_live(irq_live),
        .irq_pend(irq_pend), .wake(wake)
    );

    // reference state built from the requirements
    logic [2:0] m_s1, m_s2, m_prev, m_hit, m_mode;
    logic [2:0] m_cnt;
    logic       m_clken, m_wake;

    function automatic logic m_live();
        return (m_cnt == 3'd4);
    endfunction

    function automatic logic [2:0] exp_pend();
        logic [2:0] r;
        logic [2:0] tv;
        logic [2:0] mv;
        tv = {1'b1, trig_edge};
        mv = {1'b0, irq_mask};
        for (int i = 0; i < 3; i++) begin
            if (tv[i]) r[i] = m_hit[i] & ~mv[i];
            else       r[i] = m_live() & ~m_s2[i] & ~mv[i];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 3'b111; m_s2 <= 3'b111; m_prev <= 3'b111; m_hit <= 3'b000;
            m_cnt <= 3'd0; m_mode <= req_pins_n; m_clken <= clken_strap; m_wake <= 1'b0;
        end else begin
            m_s1 <= req_pins_n;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            if (m_cnt != 3'd4) m_cnt <= m_cnt + 3'd1;
            if (mode_wr_en) m_mode <= mode_wr_data;
            for (int i = 0; i < 3; i++) begin
                logic [2:0] tv;
                logic fl;
                tv = {1'b1, trig_edge};
                fl = m_prev[i] & ~m_s2[i];
                if (!tv[i]) m_hit[i] <= 1'b0;
                else if (m_live() && fl) m_hit[i] <= 1'b1;
                else if (irq_ack[i]) m_hit[i] <= 1'b0;
            end
            m_wake <= stop_state & m_live() & m_prev[0] & ~m_s2[0];
        end
    end

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R1 clk_en", {2'b0, clk_en}, {2'b0, m_clken});
        chk("R2 R3 boot_mode", boot_mode, m_mode);
        chk("R4 irq_live", {2'b0, irq_live}, {2'b0, m_live()});
        chk("R5 R6 R7 R9 R10 irq_pend", irq_pend, exp_pend());
        chk("R11 wake", {2'b0, wake}, {2'b0, m_wake});
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic idle_pins();
        req_pins_n = 3'b111;
        irq_ack = 3'b000;
        steps(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_pins_n = 3'b101; clken_strap = 1'b1;
        trig_edge = 2'b00; irq_mask = 2'b00; irq_ack = 3'b000;
        mode_wr_en = 1'b0; mode_wr_data = 3'b000; stop_state = 1'b0;
        steps(5);
        chk("R4 reset pend", irq_pend, 3'b000);
        chk("R2 reset mode", boot_mode, 3'b101);
        chk("R1 reset clk_en", {2'b0, clk_en}, 3'b001);

        // release, then move the straps at once
        rst_n = 1'b1; req_pins_n = 3'b111; clken_strap = 1'b0;
        steps(3);
        chk("R4 guard live", {2'b0, irq_live}, 3'b000);
        step();
        chk("R4 live after guard", {2'b0, irq_live}, 3'b001);
        chk("R2 mode kept", boot_mode, 3'b101);
        chk("R1 strap frozen", {2'b0, clk_en}, 3'b001);

        mode_wr_en = 1'b1; mode_wr_data = 3'b010;
        step();
        mode_wr_en = 1'b0;
        chk("R3 mode write", boot_mode, 3'b010);

        // level request 0 and synchroniser depth
        req_pins_n[0] = 1'b0;
        step();
        chk("R5 one edge", irq_pend, 3'b000);
        step();
        chk("R5 two edges", irq_pend, 3'b001);
        irq_ack[0] = 1'b1;
        step();
        chk("R6 ack ignored", irq_pend, 3'b001);
        idle_pins();
        chk("R6 pin high", irq_pend, 3'b000);

        // non-maskable edge capture and hold
        req_pins_n[2] = 1'b0;
        steps(2);
        chk("R7 before capture", irq_pend, 3'b000);
        step();
        chk("R7 captured", irq_pend, 3'b100);
        req_pins_n[2] = 1'b1;
        steps(3);
        chk("R7 held", irq_pend, 3'b100);
        irq_ack[2] = 1'b1;
        step();
        irq_ack[2] = 1'b0;
        chk("R7 acked", irq_pend, 3'b000);

        // set wins over a simultaneous acknowledge
        irq_ack[2] = 1'b1; req_pins_n[2] = 1'b0;
        steps(3);
        chk("R8 set wins", irq_pend, 3'b100);
        step();
        chk("R8 later ack", irq_pend, 3'b000);
        irq_ack[2] = 1'b0;
        steps(3);
        chk("R10 no relevel", irq_pend, 3'b000);
        idle_pins();

        // masked edge capture on request 1
        trig_edge = 2'b10; irq_mask = 2'b10; req_pins_n[1] = 1'b0;
        steps(3);
        chk("R9 masked", irq_pend, 3'b000);
        irq_mask = 2'b00;
        step();
        chk("R9 unmasked", irq_pend, 3'b010);
        irq_ack[1] = 1'b1;
        idle_pins();

        // wake pulse from request 0 in stop state
        stop_state = 1'b1; trig_edge = 2'b01; irq_mask = 2'b01; req_pins_n[0] = 1'b0;
        steps(2);
        chk("R11 no wake yet", {2'b0, wake}, 3'b000);
        step();
        chk("R11 wake", {2'b0, wake}, 3'b001);
        step();
        chk("R11 single", {2'b0, wake}, 3'b000);
        stop_state = 1'b0;
        idle_pins();
        req_pins_n[0] = 1'b0;
        steps(4);
        chk("R11 no stop", {2'b0, wake}, 3'b000);
        idle_pins();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < 3; b++)
                if ($urandom_range(7) == 0) req_pins_n[b] = ~req_pins_n[b];
            if ($urandom_range(63) == 0) trig_edge = 2'($urandom);
            if ($urandom_range(15) == 0) irq_mask = 2'($urandom);
            irq_ack = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000;
            mode_wr_en = ($urandom_range(31) == 0);
            mode_wr_data = 3'($urandom);
            if ($urandom_range(31) == 0) stop_state = ~stop_state;
            clken_strap = 1'($urandom);
            rst_n = !(c >= 2000 && c < 2004);
            step();
        end
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule